// File: doc/BRIEF.md
# Packed Multimedia ALU Execute Slice

This block is the execute stage for the packed multimedia opcode space of a MIPS-style core. Each cycle it can take one 32-bit instruction word together with the two source register values. It decodes the word, computes a packed byte subtract, packed NOR, packed OR or packed AND, and one clock later presents a writeback value, the destination register index, a write strobe and a trap flag.

The decode is kept narrow on purpose. An operation is accepted only when three fields all match one listed pair: the major opcode, the funct group and the 5-bit sub-op field. Any other word that carries the multimedia major opcode raises the unsupported-instruction trap and does not write. Words with any other major opcode get neither a trap nor a write, so another execute unit can handle them.

A small state register holds the kind of result being presented. `ST_IDLE` means no result. `ST_WRITE` means a valid result that writes back. `ST_SILENT` means a valid result that does not write, either because the destination is register zero or because the word is not in this unit's opcode space. `ST_TRAP` means the word was an unsupported multimedia encoding. The state is chosen again at every clock edge. When `valid_in` is low the next state is `ST_IDLE`. Otherwise the decode picks one of the other three states, and any state can move to any other.

Top module: `mmi_exec_slice`

## Requirements
- R1: When `valid_in` is high at a clock edge, `valid_out` is high in the cycle after that edge. When `valid_in` is low at an edge, `valid_out` is low after it.
- R2: A synchronous active-high `rst` drives `valid_out`, `trap` and `wb_en` low at the next edge.
- R3: Packed byte subtract has major opcode 0x1C in bits [31:26], funct 0x08 in bits [5:0] and sub-op 0x09 in bits [10:6]. Each 8-bit lane of the result is the rs lane minus the rt lane, modulo 256.
- R4: In a packed byte subtract, a borrow never crosses a lane boundary. For example, 0x12345600 minus 0x00000001 gives 0x123456FF.
- R5: Packed NOR (funct 0x29, sub-op 0x13) returns ~(rs | rt). The word 0x70091CE9 is this operation with rs=0, rt=9 and rd=3.
- R6: Packed OR (funct 0x29, sub-op 0x12) returns rs | rt.
- R7: Packed AND (funct 0x09, sub-op 0x12) returns rs & rt.
- R8: Any other funct/sub-op pair under major opcode 0x1C gives `trap` high and `wb_en` low, together with `valid_out`.
- R9: A word whose major opcode is not 0x1C gives `valid_out` high with `trap` and `wb_en` both low.
- R10: When the rd field (bits [15:11]) is zero, `wb_en` stays low for an accepted operation, and `trap` stays low.
- R11: `wb_rd` reports the rd field of the instruction that produced the current result. The rs field is in bits [25:21] and the rt field is in bits [20:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Instruction word and operands are present |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the rs source register |
| rt_val | input | 32 | Value of the rt source register |
| valid_out | output | 1 | A result is presented this cycle |
| wb_data | output | 32 | Writeback value |
| wb_rd | output | 5 | Destination register index |
| wb_en | output | 1 | Register write strobe |
| trap | output | 1 | Unsupported multimedia instruction |

## Verification
Every result is due exactly one clock after the edge that captures `valid_in`, because the slice has a single register stage. The bench changes inputs on the falling edge and samples the outputs on the next falling edge, half a period after the capturing rising edge. A reset or a cycle with `valid_in` low is checked the same way: the outputs are sampled on the falling edge after the edge that sees it. Back-to-back words are checked one per cycle, so each result is compared against the vector it belongs to.

// File: rtl/mmi_pkg.sv
package mmi_pkg;

    localparam logic [5:0] MAJ_MMI     = 6'h1C;
    localparam logic [5:0] GRP_MMI0    = 6'h08;
    localparam logic [5:0] GRP_MMI2    = 6'h09;
    localparam logic [5:0] GRP_MMI3    = 6'h29;
    localparam logic [4:0] SUB_PSUBB   = 5'h09;
    localparam logic [4:0] SUB_PAND    = 5'h12;
    localparam logic [4:0] SUB_POR     = 5'h12;
    localparam logic [4:0] SUB_PNOR    = 5'h13;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PSUBB,
        OP_PNOR,
        OP_POR,
        OP_PAND
    } mmi_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_SILENT,
        ST_TRAP
    } slice_state_e;

    typedef struct packed {
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] sa;
        logic [5:0] funct;
        logic [5:0] major;
    } instr_fields_t;

endpackage

// File: rtl/mmi_decode.sv
module mmi_decode
    import mmi_pkg::*;
(
    input  logic [31:0] instr,
    output mmi_op_e     op,
    output logic        claim,
    output logic        illegal,
    output logic [4:0]  rd
);
    instr_fields_t f;

    always_comb begin
        f.major = instr[31:26];
        f.rs    = instr[25:21];
        f.rt    = instr[20:16];
        f.rd    = instr[15:11];
        f.sa    = instr[10:6];
        f.funct = instr[5:0];
    end

    // All three fields must match; anything else stays OP_NONE.
    always_comb begin
        op = OP_NONE;
        if (f.major == MAJ_MMI) begin
            if (f.funct == GRP_MMI0 && f.sa == SUB_PSUBB)
                op = OP_PSUBB;
            else if (f.funct == GRP_MMI3 && f.sa == SUB_PNOR)
                op = OP_PNOR;
            else if (f.funct == GRP_MMI3 && f.sa == SUB_POR)
                op = OP_POR;
            else if (f.funct == GRP_MMI2 && f.sa == SUB_PAND)
                op = OP_PAND;
        end
    end

    assign claim   = (f.major == MAJ_MMI);
    assign illegal = claim && (op == OP_NONE);
    assign rd      = f.rd;

endmodule

// File: rtl/mmi_lane_unit.sv
module mmi_lane_unit
    import mmi_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  mmi_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] diff;

    // Each lane is its own subtractor, so no borrow can reach a neighbour.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign diff[g*LANE_W +: LANE_W] = a[g*LANE_W +: LANE_W] - b[g*LANE_W +: LANE_W];
    end

    always_comb begin
        unique case (op)
            OP_PSUBB: y = diff;
            OP_PNOR:  y = ~(a | b);
            OP_POR:   y = a | b;
            OP_PAND:  y = a & b;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/mmi_exec_slice.sv
module mmi_exec_slice
    import mmi_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic              valid_out,
    output logic [DATA_W-1:0] wb_data,
    output logic [4:0]        wb_rd,
    output logic              wb_en,
    output logic              trap
);
    mmi_op_e           dec_op;
    logic              dec_claim;
    logic              dec_illegal;
    logic [4:0]        dec_rd;
    logic [DATA_W-1:0] alu_y;
    slice_state_e      state, state_nxt;

    mmi_decode u_dec (
        .instr   (instr),
        .op      (dec_op),
        .claim   (dec_claim),
        .illegal (dec_illegal),
        .rd      (dec_rd)
    );

    mmi_lane_unit #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_alu (
        .op (dec_op),
        .a  (rs_val),
        .b  (rt_val),
        .y  (alu_y)
    );

    always_comb begin
        state_nxt = ST_IDLE;
        if (valid_in) begin
            if (!dec_claim)
                state_nxt = ST_SILENT;
            else if (dec_illegal)
                state_nxt = ST_TRAP;
            else if (dec_rd == 5'd0)
                state_nxt = ST_SILENT;
            else
                state_nxt = ST_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (valid_in) begin
            wb_data <= alu_y;
            wb_rd   <= dec_rd;
        end
    end

    always_comb begin
        valid_out = 1'b0;
        wb_en     = 1'b0;
        trap      = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_WRITE:  begin valid_out = 1'b1; wb_en = 1'b1; end
            ST_SILENT: valid_out = 1'b1;
            ST_TRAP:   begin valid_out = 1'b1; trap = 1'b1; end
            default:   ;
        endcase
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!valid_out && !trap && !wb_en));

    // R8
    unlisted_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && instr[31:26] == MAJ_MMI && dec_op == OP_NONE) |=> (trap && !wb_en));

    // R9
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && instr[31:26] != MAJ_MMI) |=> (!trap && !wb_en));

    // R10
    zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && instr[15:11] == 5'd0) |=> !wb_en);

    // R11
    rd_track_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (wb_rd == $past(instr[15:11])));

endmodule

// File: tb/tb_mmi_exec_slice.sv
module tb_mmi_exec_slice;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        valid_out;
    logic [31:0] wb_data;
    logic [4:0]  wb_rd;
    logic        wb_en;
    logic        trap;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mmi_exec_slice dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .valid_out(valid_out),
        .wb_data(wb_data), .wb_rd(wb_rd), .wb_en(wb_en), .trap(trap)
    );

    function automatic logic [31:0] enc(input logic [5:0] maj, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [4:0] sa, input logic [5:0] fn);
        return {maj, rs, rt, rd, sa, fn};
    endfunction

    // {req, instr, rs, rt, expected data, expected wb_en, expected trap}
    localparam int NV = 13;
    localparam logic [133:0] VEC [NV] = '{
        {4'd3,  enc(6'h1C,5'd9,5'd10,5'd2,5'h09,6'h08), 32'h10203040, 32'h01020304, 32'h0F1E2D3C, 1'b1, 1'b0}, // R3
        {4'd3,  enc(6'h1C,5'd11,5'd12,5'd13,5'h09,6'h08), 32'h00000000, 32'h01020304, 32'hFFFEFDFC, 1'b1, 1'b0}, // R3
        {4'd4,  enc(6'h1C,5'd14,5'd15,5'd24,5'h09,6'h08), 32'h12345600, 32'h00000001, 32'h123456FF, 1'b1, 1'b0}, // R4
        {4'd5,  32'h70091CE9, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0}, // R5
        {4'd5,  32'h70091CE9, 32'h00000000, 32'hAAAAAAAA, 32'h55555555, 1'b1, 1'b0}, // R5
        {4'd5,  enc(6'h1C,5'd1,5'd2,5'd4,5'h13,6'h29), 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000, 1'b1, 1'b0}, // R5
        {4'd6,  enc(6'h1C,5'd1,5'd2,5'd5,5'h12,6'h29), 32'h12300000, 32'h00000456, 32'h12300456, 1'b1, 1'b0}, // R6
        {4'd7,  enc(6'h1C,5'd1,5'd2,5'd6,5'h12,6'h09), 32'hFF00FF00, 32'h0FF00FF0, 32'h0F000F00, 1'b1, 1'b0}, // R7
        {4'd8,  enc(6'h1C,5'd1,5'd2,5'd7,5'h08,6'h08), 32'h11111111, 32'h22222222, 32'h0, 1'b0, 1'b1}, // R8
        {4'd8,  enc(6'h1C,5'd1,5'd2,5'd8,5'h14,6'h29), 32'h11111111, 32'h22222222, 32'h0, 1'b0, 1'b1}, // R8
        {4'd8,  enc(6'h1C,5'd1,5'd2,5'd9,5'h13,6'h09), 32'h11111111, 32'h22222222, 32'h0, 1'b0, 1'b1}, // R8
        {4'd9,  enc(6'h00,5'd1,5'd2,5'd10,5'h00,6'h27), 32'h11111111, 32'h22222222, 32'h0, 1'b0, 1'b0}, // R9
        {4'd10, enc(6'h1C,5'd1,5'd2,5'd0,5'h13,6'h29), 32'h11111111, 32'h22222222, 32'h0, 1'b0, 1'b0}  // R10
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        // R2 reset state
        check("R2", "valid_out", {31'b0, valid_out}, 32'd0);
        check("R2", "trap", {31'b0, trap}, 32'd0);
        check("R2", "wb_en", {31'b0, wb_en}, 32'd0);
        rst = 1'b0;

        // Vector table, one word per cycle, result sampled one cycle later.
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", int'(VEC[i][133:130]));
            valid_in = 1'b1;
            instr    = VEC[i][129:98];
            rs_val   = VEC[i][97:66];
            rt_val   = VEC[i][65:34];
            @(negedge clk);
            check("R1", "valid_out", {31'b0, valid_out}, 32'd1);
            check(tag, "wb_en", {31'b0, wb_en}, {31'b0, VEC[i][1]});
            check(tag, "trap", {31'b0, trap}, {31'b0, VEC[i][0]});
            check("R11", "wb_rd", {27'b0, wb_rd}, {27'b0, VEC[i][113:109]});
            if (VEC[i][1]) check(tag, "wb_data", wb_data, VEC[i][33:2]);
        end

        // R1 idle cycle after the stream
        valid_in = 1'b0;
        @(negedge clk);
        check("R1", "valid_out idle", {31'b0, valid_out}, 32'd0);
        check("R1", "wb_en idle", {31'b0, wb_en}, 32'd0);

        // R4 borrow chain across every lane boundary stays local
        valid_in = 1'b1;
        instr  = enc(6'h1C, 5'd3, 5'd4, 5'd5, 5'h09, 6'h08);
        rs_val = 32'h00000000;
        rt_val = 32'h00010001;
        @(negedge clk);
        check("R4", "wb_data", wb_data, 32'h00FF00FF);

        // R2 reset during a trap result clears it
        instr = enc(6'h1C, 5'd1, 5'd1, 5'd1, 5'h1F, 6'h29);
        @(negedge clk);
        check("R8", "trap before reset", {31'b0, trap}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        check("R2", "trap after reset", {31'b0, trap}, 32'd0);
        check("R2", "valid after reset", {31'b0, valid_out}, 32'd0);
        rst = 1'b0;
        valid_in = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule